// File: doc/BRIEF.md
# MESI Line Coherence Cost Tracker

This block follows a single cache line shared by a small group of processors on a common bus. Each processor has a writeback cache that uses an invalidation protocol with the four states Modified, Exclusive, Shared and Invalid. Caches never supply data to one another, so every miss is served by a full block transfer from memory. The block holds no data and models no eviction and no bus timing. It tracks only the state of the line in each cache and the cost of each access.

A request names a processor and says whether it reads or writes. The block accepts it through a valid/ready handshake and puts it in one of four classes: hit, read miss, upgrade or read-exclusive. It moves every cache to its new state and charges a fixed cycle cost for the class. One cycle later it reports a single response beat. The beat carries the class, the bus transaction issued, the cost charged, the new state of every cache and the running total, which saturates. The block is used to compare the cost of access streams, such as lock or sharing patterns.

Top module: `mesi_cost_tracker`

## Requirements
- R1: After synchronous reset every cache holds the line Invalid (state code 0 in each 2-bit field of `rsp_states`), `rsp_total` is 0 and `rsp_valid` is 0.
- R2: A read by a processor whose copy is Shared, Exclusive or Modified is a hit: outcome code 0, bus code 0, cost `HIT_COST` (default 1), and no cache changes state.
- R3: A read by a processor whose copy is Invalid is a read miss: outcome code 1, bus code 1, cost `BLOCK_COST` (default 90). The requester becomes Exclusive (code 2) if no other cache holds the line, otherwise Shared (code 1). Any other Modified (code 3) or Exclusive copy becomes Shared.
- R4: A write by a processor whose copy is Shared is an upgrade: outcome code 2, bus code 2, cost `UPGRADE_COST` (default 60). The requester becomes Modified and every other copy becomes Invalid.
- R5: A write by a processor whose copy is Invalid is a read-exclusive: outcome code 3, bus code 3, cost `BLOCK_COST`. The requester becomes Modified and every other copy becomes Invalid.
- R6: A write by a processor whose copy is Exclusive or Modified is a hit: outcome code 0, bus code 0, cost `HIT_COST`. The requester ends Modified and the other caches are unchanged.
- R7: `rsp_total` is the sum of the costs of all requests accepted since reset. It saturates at the all-ones value of `TOTAL_W` bits. From the empty state, the stream r0 w0 r0 w0 r1 w1 r1 w1 r2 w2 r2 w2 totals 397, the stream r0 r1 r2 w0 w1 w2 r0 r1 r2 w2 w0 totals 841, and the stream r0 r1 r2 r2 w0 w0 w0 w0 w1 w2 totals 514.
- R8: `req_ready` is high whenever reset is low. Each accepted request produces exactly one cycle of `rsp_valid`, in the cycle after acceptance, and `rsp_valid` is low in every other cycle.
- R9: Whenever any cache holds the line Modified or Exclusive, every other cache holds it Invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_cpu | input | IDX_W | Index of the requesting processor (below NPROC) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Response beat present |
| rsp_outcome | output | 2 | 0 hit, 1 read miss, 2 upgrade, 3 read-exclusive |
| rsp_bus | output | 2 | 0 none, 1 bus read, 2 bus upgrade, 3 bus read-exclusive |
| rsp_cost | output | COST_W | Cycles charged for this access |
| rsp_states | output | 2*NPROC | Line state per cache, cache i in bits [2i+1:2i] |
| rsp_total | output | TOTAL_W | Saturating running total of cycles |

## Verification
Three fixed sharing streams, where one, two or three processors read and write in turn, separate the cost of upgrades from the cost of block transfers. Each stream is checked against its known total. Every sequence of three requests over all processors and both directions is then run from the empty line. This covers every reachable transition into and out of each state, and in particular tells an Exclusive install (sole reader) apart from a Shared install and a silent Exclusive-to-Modified write from an upgrade. A second instance with a narrow total shows that the total stops at the all-ones value and does not wrap.

// File: rtl/mesi_cost_pkg.sv
package mesi_cost_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        OC_HIT     = 2'd0,
        OC_RDMISS  = 2'd1,
        OC_UPGRADE = 2'd2,
        OC_RDX     = 2'd3
    } outcome_t;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_UPGR = 2'd2,
        BUS_RDX  = 2'd3
    } bus_op_t;

    typedef struct packed {
        logic     valid;
        outcome_t outcome;
    } rsp_head_t;

    function automatic bus_op_t bus_for(outcome_t oc);
        case (oc)
            OC_RDMISS:  return BUS_RD;
            OC_UPGRADE: return BUS_UPGR;
            OC_RDX:     return BUS_RDX;
            default:    return BUS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mesi_line_update.sv
module mesi_line_update
    import mesi_cost_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int IDX_W = $clog2(NPROC)
) (
    input  line_st_t               cur [NPROC],
    input  logic     [IDX_W-1:0]   cpu,
    input  logic                   write,
    output line_st_t               nxt [NPROC],
    output outcome_t               outcome
);

    line_st_t own;
    logic     others_valid;

    always_comb begin
        own          = cur[cpu];
        others_valid = 1'b0;
        for (int j = 0; j < NPROC; j++) begin
            if (j != int'(cpu) && cur[j] != ST_I) others_valid = 1'b1;
        end
    end

    always_comb begin
        for (int j = 0; j < NPROC; j++) nxt[j] = cur[j];
        outcome = OC_HIT;
        if (!write) begin
            if (own == ST_I) begin
                outcome = OC_RDMISS;
                for (int j = 0; j < NPROC; j++) begin
                    if (j == int'(cpu))
                        nxt[j] = others_valid ? ST_S : ST_E;
                    else if (cur[j] == ST_M || cur[j] == ST_E)
                        nxt[j] = ST_S;
                end
            end
        end else begin
            case (own)
                ST_S:    outcome = OC_UPGRADE;
                ST_I:    outcome = OC_RDX;
                default: outcome = OC_HIT;
            endcase
            for (int j = 0; j < NPROC; j++) begin
                if (j == int'(cpu))
                    nxt[j] = ST_M;
                else if (own == ST_S || own == ST_I)
                    nxt[j] = ST_I;
            end
        end
    end

endmodule

// File: rtl/mesi_cost_accum.sv
module mesi_cost_accum #(
    parameter int TOTAL_W = 32,
    parameter int COST_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               add_en,
    input  logic [COST_W-1:0]  cost,
    output logic [TOTAL_W-1:0] total
);

    localparam int SUM_W = TOTAL_W + 1;

    logic [SUM_W-1:0] sum;

    assign sum = SUM_W'(total) + SUM_W'(cost);

    always_ff @(posedge clk) begin
        if (rst) begin
            total <= '0;
        end else if (add_en) begin
            total <= sum[TOTAL_W] ? {TOTAL_W{1'b1}} : sum[TOTAL_W-1:0];
        end
    end

endmodule

// File: rtl/mesi_cost_tracker.sv
module mesi_cost_tracker
    import mesi_cost_pkg::*;
#(
    parameter int NPROC        = 4,
    parameter int IDX_W        = $clog2(NPROC),
    parameter int COST_W       = 8,
    parameter int TOTAL_W      = 32,
    parameter int HIT_COST     = 1,
    parameter int UPGRADE_COST = 60,
    parameter int BLOCK_COST   = 90
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [IDX_W-1:0]     req_cpu,
    input  logic                 req_write,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_outcome,
    output logic [1:0]           rsp_bus,
    output logic [COST_W-1:0]    rsp_cost,
    output logic [2*NPROC-1:0]   rsp_states,
    output logic [TOTAL_W-1:0]   rsp_total
);

    localparam logic [COST_W-1:0] C_HIT = COST_W'(HIT_COST);
    localparam logic [COST_W-1:0] C_UPG = COST_W'(UPGRADE_COST);
    localparam logic [COST_W-1:0] C_BLK = COST_W'(BLOCK_COST);

    line_st_t          st_q  [NPROC];
    line_st_t          st_d  [NPROC];
    outcome_t          oc_d;
    logic [COST_W-1:0] cost_d;
    logic [COST_W-1:0] cost_q;
    rsp_head_t         head_q;
    logic              accept;

    assign req_ready = !rst;
    assign accept    = req_valid && req_ready;

    mesi_line_update #(
        .NPROC (NPROC),
        .IDX_W (IDX_W)
    ) u_update (
        .cur     (st_q),
        .cpu     (req_cpu),
        .write   (req_write),
        .nxt     (st_d),
        .outcome (oc_d)
    );

    always_comb begin
        case (oc_d)
            OC_HIT:     cost_d = C_HIT;
            OC_UPGRADE: cost_d = C_UPG;
            default:    cost_d = C_BLK;
        endcase
    end

    for (genvar g = 0; g < NPROC; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)         st_q[g] <= ST_I;
            else if (accept) st_q[g] <= st_d[g];
        end
        assign rsp_states[2*g +: 2] = st_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '{valid: 1'b0, outcome: OC_HIT};
            cost_q <= '0;
        end else begin
            head_q.valid <= accept;
            if (accept) begin
                head_q.outcome <= oc_d;
                cost_q         <= cost_d;
            end
        end
    end

    mesi_cost_accum #(
        .TOTAL_W (TOTAL_W),
        .COST_W  (COST_W)
    ) u_accum (
        .clk    (clk),
        .rst    (rst),
        .add_en (accept),
        .cost   (cost_d),
        .total  (rsp_total)
    );

    assign rsp_valid   = head_q.valid;
    assign rsp_outcome = head_q.outcome;
    assign rsp_bus     = bus_for(head_q.outcome);
    assign rsp_cost    = cost_q;

endmodule

// File: rtl/mesi_cost_tracker_chk.sv
module mesi_cost_tracker_chk #(
    parameter int NPROC        = 4,
    parameter int COST_W       = 8,
    parameter int TOTAL_W      = 32,
    parameter int HIT_COST     = 1,
    parameter int UPGRADE_COST = 60,
    parameter int BLOCK_COST   = 90
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic [1:0]         rsp_outcome,
    input logic [COST_W-1:0]  rsp_cost,
    input logic [2*NPROC-1:0] rsp_states,
    input logic [TOTAL_W-1:0] rsp_total
);

    int n_valid;
    int n_own;

    always_comb begin
        n_valid = 0;
        n_own   = 0;
        for (int j = 0; j < NPROC; j++) begin
            if (rsp_states[2*j +: 2] != 2'd0) n_valid++;
            if (rsp_states[2*j +: 2] >= 2'd2) n_own++;
        end
    end

    p_beat_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    p_no_spurious_beat_r8: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    p_single_owner_r9: assert property (@(posedge clk) disable iff (rst)
        (n_own != 0) |-> (n_own == 1 && n_valid == 1));

    p_hit_cost_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_outcome == 2'd0) |-> rsp_cost == COST_W'(HIT_COST));

    p_miss_install_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_outcome == 2'd1)
            |-> (rsp_cost == COST_W'(BLOCK_COST) && (n_own == 1) == (n_valid == 1)));

    p_upgrade_sole_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_outcome == 2'd2)
            |-> (rsp_cost == COST_W'(UPGRADE_COST) && n_own == 1 && n_valid == 1));

    p_rdx_sole_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_outcome == 2'd3)
            |-> (rsp_cost == COST_W'(BLOCK_COST) && n_own == 1 && n_valid == 1));

    p_total_monotone_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(!rst)) |-> rsp_total >= $past(rsp_total));

endmodule

bind mesi_cost_tracker mesi_cost_tracker_chk #(
    .NPROC        (NPROC),
    .COST_W       (COST_W),
    .TOTAL_W      (TOTAL_W),
    .HIT_COST     (HIT_COST),
    .UPGRADE_COST (UPGRADE_COST),
    .BLOCK_COST   (BLOCK_COST)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_outcome (rsp_outcome),
    .rsp_cost    (rsp_cost),
    .rsp_states  (rsp_states),
    .rsp_total   (rsp_total)
);

// File: tb/tb_mesi_cost_tracker.sv
`timescale 1ns/1ps
module tb_mesi_cost_tracker;

    localparam int NP = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_cpu = '0;
    logic          req_write = 1'b0;
    logic          req_ready, req_ready_n;
    logic          rsp_valid, rsp_valid_n;
    logic [1:0]    rsp_outcome, rsp_outcome_n, rsp_bus, rsp_bus_n;
    logic [7:0]    rsp_cost, rsp_cost_n;
    logic [2*NP-1:0] rsp_states, rsp_states_n;
    logic [31:0]   rsp_total;
    logic [7:0]    rsp_total_n;

    always #4 clk = ~clk;

    mesi_cost_tracker #(.NPROC(NP)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cpu(req_cpu), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_outcome(rsp_outcome), .rsp_bus(rsp_bus), .rsp_cost(rsp_cost),
        .rsp_states(rsp_states), .rsp_total(rsp_total));

    mesi_cost_tracker #(.NPROC(NP), .TOTAL_W(8)) dut_narrow (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready_n),
        .req_cpu(req_cpu), .req_write(req_write), .rsp_valid(rsp_valid_n),
        .rsp_outcome(rsp_outcome_n), .rsp_bus(rsp_bus_n), .rsp_cost(rsp_cost_n),
        .rsp_states(rsp_states_n), .rsp_total(rsp_total_n));

    int checks = 0;
    int errors = 0;
    int mst [NP];
    longint tot_exp;
    int tot_n_exp;

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference: 0=I 1=S 2=E 3=M; outcome 0 hit 1 miss 2 upgrade 3 rdx
    task automatic model(input int c, input bit w, output int oc, output int cost);
        bool_others: begin end
        begin
            bit others = 0;
            for (int j = 0; j < NP; j++) if (j != c && mst[j] != 0) others = 1;
            if (!w) begin
                if (mst[c] == 0) begin
                    oc = 1; cost = 90;
                    for (int j = 0; j < NP; j++)
                        if (j != c && mst[j] >= 2) mst[j] = 1;
                    mst[c] = others ? 1 : 2;
                end else begin
                    oc = 0; cost = 1;
                end
            end else begin
                if (mst[c] >= 2) begin oc = 0; cost = 1; end
                else if (mst[c] == 1) begin oc = 2; cost = 60; end
                else begin oc = 3; cost = 90; end
                if (oc != 0) for (int j = 0; j < NP; j++) mst[j] = 0;
                mst[c] = 3;
            end
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        check("R8", "ready low in reset", req_ready, 0);
        @(negedge clk);
        rst = 1'b0;
        for (int j = 0; j < NP; j++) mst[j] = 0;
        tot_exp = 0;
        tot_n_exp = 0;
    endtask

    task automatic do_req(input int c, input bit w);
        int oc, cost;
        string tag;
        longint st_exp;
        @(negedge clk);
        check("R8", "idle rsp_valid", rsp_valid, 0);
        check("R8", "ready", req_ready, 1);
        req_valid = 1'b1;
        req_cpu   = IW'(c);
        req_write = w;
        model(c, w, oc, cost);
        tot_exp  += cost;
        tot_n_exp = (tot_n_exp + cost > 255) ? 255 : tot_n_exp + cost;
        case (oc)
            1: tag = "R3";
            2: tag = "R4";
            3: tag = "R5";
            default: tag = w ? "R6" : "R2";
        endcase
        @(negedge clk);
        req_valid = 1'b0;
        st_exp = 0;
        for (int j = 0; j < NP; j++) st_exp |= longint'(mst[j]) << (2*j);
        check("R8", "beat", rsp_valid, 1);
        check(tag, "outcome", rsp_outcome, oc);
        check(tag, "bus", rsp_bus, oc);
        check(tag, "cost", rsp_cost, cost);
        check(tag, "states", rsp_states, st_exp);
        check("R7", "total", rsp_total, tot_exp);
        check("R7", "narrow total", rsp_total_n, tot_n_exp);
    endtask

    int s1c[12] = '{0,0,0,0,1,1,1,1,2,2,2,2};
    bit s1w[12] = '{0,1,0,1,0,1,0,1,0,1,0,1};
    int s2c[11] = '{0,1,2,0,1,2,0,1,2,2,0};
    bit s2w[11] = '{0,0,0,1,1,1,0,0,0,1,1};
    int s3c[10] = '{0,1,2,2,0,0,0,0,1,2};
    bit s3w[10] = '{0,0,0,0,1,1,1,1,1,1};

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1", "states after reset", rsp_states, 0);
        check("R1", "total after reset", rsp_total, 0);
        check("R1", "rsp_valid after reset", rsp_valid, 0);

        for (int i = 0; i < 12; i++) do_req(s1c[i], s1w[i]);
        check("R7", "stream one total", rsp_total, 397);
        check("R7", "stream one narrow saturates", rsp_total_n, 255);

        do_reset();
        for (int i = 0; i < 11; i++) do_req(s2c[i], s2w[i]);
        check("R7", "stream two total", rsp_total, 841);

        do_reset();
        for (int i = 0; i < 10; i++) do_req(s3c[i], s3w[i]);
        check("R7", "stream three total", rsp_total, 514);

        for (int s = 0; s < 512; s++) begin
            do_reset();
            for (int k = 0; k < 3; k++) begin
                int r = (s >> (3*k)) & 7;
                do_req(r >> 1, bit'(r & 1));
            end
        end

        @(negedge clk);
        check("R8", "no beat when idle", rsp_valid, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule